// File: doc/BRIEF.md
# Protection Key Permission Checker

This block decides whether a paged memory access breaks a protection-key rule. It keeps two 32-bit rights registers: one applies to user pages and one to supervisor pages. Each register holds sixteen 2-bit domains. A check request carries four access-type bits, the page's user/supervisor bit and a 4-bit key. The block returns a single fault flag one cycle after it accepts the request.

The rules do not depend on the key. They depend only on the access type and on a few control inputs: the user-key enable, the supervisor-key enable, long mode and write protect. These rules are folded into a 16-entry, 2-bit mask that both register banks share. The control inputs are registered, and the mask is rebuilt from them one cycle later. During that rebuild cycle the block drops its ready signal, so no request is ever judged against a stale mask. Software loads the rights registers through a plain write port.

Top module: `pkey_checker`

## Requirements
- R1: After reset, both rights registers and the mask are zero, `rsp_valid` is 0 and `req_ready` is 1. A check made after enabling keys, with no register written, reports no fault.
- R2: In a rights register, key k uses bit 2k as its access-disable bit and bit 2k+1 as its write-disable bit. Bits that belong to other keys never affect the result for key k.
- R3: When `req_page_user` is 1, the rights come from the user register (`wr_sel`=0). When it is 0, they come from the supervisor register (`wr_sel`=1).
- R4: The fault is always 0 unless long mode is set and at least one of the two key enables is set. Both page kinds use the same single mask.
- R5: An access with the fetch bit (`req_err[3]`) or the reserved bit (`req_err[2]`) set never faults.
- R6: An access-disable bit set for the selected key faults both reads (`req_err[0]`=0) and writes (`req_err[0]`=1).
- R7: A write-disable bit faults only writes, and only when the access is a user access (`req_err[1]`=1) or write protect is 1. A supervisor write with write protect 0 passes.
- R8: After any control input changes, `req_ready` is 0 for exactly the one cycle that follows the clock edge that registers the change. A request presented in that cycle is held until the next cycle.
- R9: `rsp_valid` is 1 in exactly the cycle after a request is accepted (`req_valid` and `req_ready` both high), and 0 in all other cycles.
- R10: A request accepted on the same edge as a rights-register write uses the old register value. A request accepted on any later edge uses the new value.
- R11: A write to one rights register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_long_mode | input | 1 | Long mode active |
| ctl_ukey_en | input | 1 | User-key checking enable |
| ctl_skey_en | input | 1 | Supervisor-key checking enable |
| ctl_wp | input | 1 | Write protect applies to supervisor writes |
| wr_en | input | 1 | Rights-register write strobe |
| wr_sel | input | 1 | 0 selects the user register, 1 selects the supervisor register |
| wr_data | input | 32 | Rights-register write value |
| req_valid | input | 1 | Check request valid |
| req_ready | output | 1 | Check request can be accepted |
| req_err | input | 4 | Access bits: [0] write, [1] user access, [2] reserved, [3] fetch |
| req_page_user | input | 1 | Page user/supervisor bit (1 = user page) |
| req_key | input | 4 | Protection key of the page |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Protection-key fault |

## Verification
The properties assume that the control inputs and the request fields are stable once the clock edge that samples them has passed. They also assume that `req_valid` is low during reset. The bench changes every input only at the falling edge, and it keeps `req_valid` deasserted through reset and between requests. When a request meets a control change, the bench holds `req_valid` high until `req_ready` returns, so every acceptance it makes is a real handshake.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
   // access-type field positions are fixed by the mask indexing
   localparam int unsigned ERR_W       = 4;
   localparam int unsigned ERR_WRITE   = 0;
   localparam int unsigned ERR_USER    = 1;
   localparam int unsigned ERR_RSVD    = 2;
   localparam int unsigned ERR_FETCH   = 3;
   localparam int unsigned MASK_SLOTS  = 1 << ERR_W;
   localparam int unsigned SLOT_W      = 2;
   localparam int unsigned MASK_W      = MASK_SLOTS * SLOT_W;

   typedef struct packed {
      logic lma;
      logic uke;
      logic ske;
      logic wp;
   } pkc_ctl_t;
endpackage

// File: rtl/pkc_ctl_mask.sv
module pkc_ctl_mask
   import pkc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  pkc_ctl_t        ctl_in,
   output pkc_ctl_t        ctl_cur,
   output logic [MASK_W-1:0] mask_q,
   output logic            busy
);
   pkc_ctl_t          ctl_used;
   logic [MASK_W-1:0] mask_d;
   logic              enabled;

   assign enabled = ctl_cur.lma & (ctl_cur.uke | ctl_cur.ske);

   genvar s;
   generate
      for (s = 0; s < MASK_SLOTS; s++) begin : g_slot
         localparam logic [ERR_W-1:0] IDX = ERR_W'(s);
         logic chk, wchk;
         assign chk  = enabled & ~IDX[ERR_FETCH] & ~IDX[ERR_RSVD];
         assign wchk = chk & IDX[ERR_WRITE] & (IDX[ERR_USER] | ctl_cur.wp);
         assign mask_d[s*SLOT_W]     = chk;
         assign mask_d[s*SLOT_W + 1] = wchk;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_cur  <= '0;
         ctl_used <= '0;
         mask_q   <= '0;
      end else begin
         ctl_cur  <= ctl_in;
         ctl_used <= ctl_cur;
         mask_q   <= mask_d;
      end
   end

   assign busy = (ctl_cur != ctl_used);
endmodule

// File: rtl/pkc_key_bank.sv
module pkc_key_bank #(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] ukey_q,
   output logic [REG_W-1:0] skey_q
);
   logic [REG_W-1:0] bank_q [2];

   genvar b;
   generate
      for (b = 0; b < 2; b++) begin : g_bank
         always_ff @(posedge clk) begin
            if (!rst_n)
               bank_q[b] <= '0;
            else if (wr_en && (wr_sel == 1'(b)))
               bank_q[b] <= wr_data;
         end
      end
   endgenerate

   assign ukey_q = bank_q[0];
   assign skey_q = bank_q[1];
endmodule

// File: rtl/pkc_resolve.sv
module pkc_resolve
   import pkc_pkg::*;
#(
   parameter int unsigned NUM_KEYS = 16,
   localparam int unsigned KEY_W   = $clog2(NUM_KEYS),
   localparam int unsigned REG_W   = NUM_KEYS * 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ERR_W-1:0]  err,
   input  logic              page_user,
   input  logic [KEY_W-1:0]  key,
   input  logic [MASK_W-1:0] mask,
   input  logic [REG_W-1:0]  ukey,
   input  logic [REG_W-1:0]  skey,
   output logic              rsp_valid,
   output logic              rsp_fault
);
   logic [REG_W-1:0] rights_reg;
   logic [1:0]       rights, gate;

   assign rights_reg = page_user ? ukey : skey;
   assign rights     = rights_reg[{key, 1'b0} +: 2];
   assign gate       = mask[{err, 1'b0} +: 2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept)
            rsp_fault <= |(rights & gate);
      end
   end
endmodule

// File: rtl/pkey_checker.sv
module pkey_checker
   import pkc_pkg::*;
#(
   parameter int unsigned NUM_KEYS = 16,
   localparam int unsigned KEY_W   = $clog2(NUM_KEYS),
   localparam int unsigned REG_W   = NUM_KEYS * 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_long_mode,
   input  logic             ctl_ukey_en,
   input  logic             ctl_skey_en,
   input  logic             ctl_wp,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [ERR_W-1:0] req_err,
   input  logic             req_page_user,
   input  logic [KEY_W-1:0] req_key,
   output logic             rsp_valid,
   output logic             rsp_fault
);
   generate
      if (NUM_KEYS < 2 || (NUM_KEYS & (NUM_KEYS - 1)) != 0) begin : g_bad_keys
         $error("NUM_KEYS must be a power of two of at least 2");
      end
   endgenerate

   pkc_ctl_t          ctl_in, ctl_cur;
   logic [MASK_W-1:0] mask_q;
   logic              busy, accept;
   logic [REG_W-1:0]  ukey_q, skey_q;

   assign ctl_in    = '{lma: ctl_long_mode, uke: ctl_ukey_en,
                        ske: ctl_skey_en,   wp:  ctl_wp};
   assign req_ready = ~busy;
   assign accept    = req_valid & req_ready;

   pkc_ctl_mask u_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in),
      .ctl_cur(ctl_cur), .mask_q(mask_q), .busy(busy)
   );

   pkc_key_bank #(.REG_W(REG_W)) u_keys (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ukey_q(ukey_q), .skey_q(skey_q)
   );

   pkc_resolve #(.NUM_KEYS(NUM_KEYS)) u_res (
      .clk(clk), .rst_n(rst_n), .accept(accept), .err(req_err),
      .page_user(req_page_user), .key(req_key), .mask(mask_q),
      .ukey(ukey_q), .skey(skey_q),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
   );
endmodule

// File: rtl/pkc_checker.sv
module pkc_checker
   import pkc_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [ERR_W-1:0] req_err,
   input logic [3:0]       ctl_vec,
   input pkc_ctl_t         ctl_cur,
   input logic             rsp_valid,
   input logic             rsp_fault
);
   logic acc;
   assign acc = req_valid & req_ready;

   // R9: a response follows every accepted request
   a_r9_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);

   // R9: no response without an acceptance
   a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !rsp_valid);

   // R8: a control change closes the request port for the following cycle
   a_r8_busy_after_change: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_vec != $past(ctl_vec)) |=> !req_ready);

   // R5: fetch or reserved accesses never fault
   a_r5_fetch_rsvd_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (req_err[ERR_FETCH] || req_err[ERR_RSVD])) |=> !rsp_fault);

   // R4: disabled key checking never faults
   a_r4_disabled_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !(ctl_cur.lma && (ctl_cur.uke || ctl_cur.ske))) |=> !rsp_fault);
endmodule

bind pkey_checker pkc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_err(req_err),
   .ctl_vec({ctl_long_mode, ctl_ukey_en, ctl_skey_en, ctl_wp}),
   .ctl_cur(ctl_cur), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
);

// File: tb/sim_pkey_checker.sv
module sim_pkey_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_long_mode = 0, ctl_ukey_en = 0, ctl_skey_en = 0, ctl_wp = 0;
   logic        wr_en = 0, wr_sel = 0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 0;
   logic        req_ready;
   logic [3:0]  req_err = '0;
   logic        req_page_user = 0;
   logic [3:0]  req_key = '0;
   logic        rsp_valid, rsp_fault;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pkey_checker u0 (
      .clk(clk), .rst_n(rst_n), .ctl_long_mode(ctl_long_mode),
      .ctl_ukey_en(ctl_ukey_en), .ctl_skey_en(ctl_skey_en), .ctl_wp(ctl_wp),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_err(req_err),
      .req_page_user(req_page_user), .req_key(req_key),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
   );

   task automatic check(string tag, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic set_ctl(logic lma, logic uke, logic ske, logic wp);
      @(negedge clk);
      ctl_long_mode = lma; ctl_ukey_en = uke; ctl_skey_en = ske; ctl_wp = wp;
      @(negedge clk);
      check("R8 ready low after control change", req_ready, 1'b0);
      @(negedge clk);
      check("R8 ready back after rebuild", req_ready, 1'b1);
   endtask

   task automatic write_key(logic sel, logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic probe(string tag, logic [3:0] err, logic pu, logic [3:0] key, logic exp);
      @(negedge clk);
      req_valid = 1; req_err = err; req_page_user = pu; req_key = key;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      check({tag, " rsp_valid"}, rsp_valid, 1'b1);
      check(tag, rsp_fault, exp);
      @(negedge clk);
      check("R9 rsp_valid drops", rsp_valid, 1'b0);
   endtask

   task automatic t_reset();
      check("R1 rsp_valid at reset", rsp_valid, 1'b0);
      check("R1 ready at reset", req_ready, 1'b1);
      set_ctl(1, 1, 1, 1);
      probe("R1 user regs clear", 4'b0011, 1, 4'd0, 0);
      probe("R1 sup regs clear", 4'b0001, 0, 4'd15, 0);
   endtask

   task automatic t_enable();
      write_key(0, 32'hFFFF_FFFF);
      set_ctl(0, 1, 0, 1);
      probe("R4 no long mode", 4'b0010, 1, 4'd2, 0);
      set_ctl(1, 0, 0, 1);
      probe("R4 no enables", 4'b0010, 1, 4'd2, 0);
      set_ctl(1, 0, 1, 1);
      probe("R4 shared mask via sup enable", 4'b0010, 1, 4'd2, 1);
      set_ctl(1, 1, 0, 1);
      probe("R4 user enable", 4'b0010, 1, 4'd2, 1);
   endtask

   task automatic t_access_disable();
      write_key(0, 32'h1 << 10);
      probe("R6 AD read key5", 4'b0010, 1, 4'd5, 1);
      probe("R6 AD write key5", 4'b0011, 1, 4'd5, 1);
      probe("R2 key4 unaffected", 4'b0011, 1, 4'd4, 0);
      probe("R2 key6 unaffected", 4'b0011, 1, 4'd6, 0);
   endtask

   task automatic t_write_disable();
      write_key(0, 32'h1 << 15);
      probe("R7 WD read passes", 4'b0010, 1, 4'd7, 0);
      probe("R7 WD user write", 4'b0011, 1, 4'd7, 1);
      set_ctl(1, 1, 0, 0);
      probe("R7 sup write wp0 passes", 4'b0001, 1, 4'd7, 0);
      probe("R7 user write wp0", 4'b0011, 1, 4'd7, 1);
      set_ctl(1, 1, 0, 1);
      probe("R7 sup write wp1", 4'b0001, 1, 4'd7, 1);
   endtask

   task automatic t_select();
      write_key(0, 32'h0);
      write_key(1, 32'h1 << 6);
      probe("R3 sup page uses sup reg", 4'b0000, 0, 4'd3, 1);
      probe("R3 user page uses user reg", 4'b0000, 1, 4'd3, 0);
      write_key(0, 32'h0000_0F00);
      probe("R11 sup reg kept", 4'b0000, 0, 4'd3, 1);
      probe("R5 fetch no fault", 4'b1000, 0, 4'd3, 0);
      probe("R5 reserved no fault", 4'b0100, 0, 4'd3, 0);
   endtask

   task automatic t_write_race();
      write_key(0, 32'h0);
      @(negedge clk);
      wr_en = 1; wr_sel = 0; wr_data = 32'h1 << 18;
      req_valid = 1; req_err = 4'b0010; req_page_user = 1; req_key = 4'd9;
      @(negedge clk);
      wr_en = 0; req_valid = 0;
      check("R10 same-edge uses old", rsp_fault, 1'b0);
      probe("R10 later uses new", 4'b0010, 1, 4'd9, 1);
   endtask

   task automatic t_hold();
      @(negedge clk);
      ctl_wp = 0;
      @(negedge clk);
      req_valid = 1; req_err = 4'b0010; req_page_user = 1; req_key = 4'd9;
      check("R8 held while rebuilding", req_ready, 1'b0);
      @(negedge clk);
      check("R8 no response while held", rsp_valid, 1'b0);
      check("R8 ready after rebuild", req_ready, 1'b1);
      @(negedge clk);
      req_valid = 0;
      check("R9 response after held accept", rsp_valid, 1'b1);
      check("R8 held request result", rsp_fault, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_access_disable();
      t_write_disable();
      t_select();
      t_write_race();
      t_hold();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule